// File: doc/BRIEF.md
# Bootstrap Supervisor and Fault Merger

This block supervises the floating high-side supplies of a multi-phase MOSFET bridge driver and folds every fault source into one active-high fault line. For each phase it takes that phase's high-side command and two digitised bootstrap comparator results. One result says the bootstrap voltage is high enough to start conduction. The other says it is still high enough to keep conducting. If the supply is too weak at the moment of turn-on, or sags afterwards, only that phase's high-side gate is inhibited. The inhibit stays latched until the command for that phase is withdrawn.

Regulated-supply undervoltage, over-temperature and the drain-source monitor flags are merged with the latched bootstrap trips into the fault drive. Supply undervoltage also produces a global gate inhibit, which is not latched. The fault line can be clamped low by outside circuitry. An asynchronous detect of that clamp passes through a parameterised synchroniser. While the clamp is seen, bootstrap supervision neither blocks gates nor raises the fault. The other fault actions keep working.

Top module: `bootstrap_fault_guard`

## Requirements
- R1: While rst_n is low, hs_block is all zero, and gate_off_all and flt_drive are both 1.
- R2: If the clamp is not seen and a phase's hs_cmd is high while that phase is off (previous cycle low, or first cycle after reset), a low boot_on_ok on that phase sets hs_block on that phase and flt_drive at the next clock edge.
- R3: If a phase turned on with boot_on_ok high, a later cycle with hs_cmd still high and boot_hold_ok low sets that phase's hs_block and flt_drive at the next edge.
- R4: A set hs_block bit stays set while its hs_cmd stays high, even if both comparators recover. It clears at the first edge that samples hs_cmd low.
- R5: A trip on one phase leaves the hs_block bits of all other phases at 0.
- R6: The clamp input passes through SYNC_STAGES flip-flops (default 2). Three edges after the clamp rises, with the default, any latched trip is cleared. While the clamp is seen, no trip is set and bootstrap trips add nothing to flt_drive. After release, supervision is re-armed on phases whose command is still high.
- R7: The clamp does not mask supply undervoltage: gate_off_all and flt_drive still follow supply_uv while the clamp is seen.
- R8: supply_uv high sets gate_off_all and flt_drive at the next edge. Both clear at the next edge after supply_uv falls, provided no other fault is present. Nothing is latched.
- R9: over_temp high sets flt_drive at the next edge and affects neither gate_off_all nor hs_block.
- R10: Any set bit of vds_flt sets flt_drive at the next edge and inhibits no gate.
- R11: While a phase's hs_cmd is low, its comparator inputs have no effect on hs_block or flt_drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_cmd | input | NUM_PHASES | High-side on command per phase |
| boot_on_ok | input | NUM_PHASES | Bootstrap above turn-on level |
| boot_hold_ok | input | NUM_PHASES | Bootstrap above hold level |
| supply_uv | input | 1 | Regulated-supply undervoltage |
| over_temp | input | 1 | Over-temperature warning |
| vds_flt | input | NUM_VDS | Drain-source monitor fault flags |
| fault_clamp_async | input | 1 | Fault line seen clamped low externally (asynchronous) |
| hs_block | output | NUM_PHASES | Per-phase high-side gate inhibit |
| gate_off_all | output | 1 | Inhibit for all gates |
| flt_drive | output | 1 | Active-high fault line drive |

## Verification
A bootstrap trip and a supply undervoltage can land on the same clock edge. The bench provokes this by raising supply_uv in the same cycle that both phases request turn-on with a weak bootstrap. It then expects hs_block, gate_off_all and flt_drive all set at the following edge. When supply_uv falls one cycle later, it expects gate_off_all to clear at once while the latched trips keep hs_block and flt_drive high. A second overlap is checked by raising the clamp while trips are already latched. That case confirms that the trips clear exactly at the edge where the synchronised clamp arrives, and not earlier.

// File: rtl/bootflt_pkg.sv
package bootflt_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ON   = 2'd1,
      PH_TRIP = 2'd2
   } phase_state_e;
endpackage

// File: rtl/clamp_sync.sv
module clamp_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_out = async_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else if (STAGES == 1) chain_q <= async_in;
            else chain_q <= {chain_q[STAGES-2:0], async_in};
         end
         assign sync_out = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/boot_phase_guard.sv
module boot_phase_guard
   import bootflt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hs_cmd,
   input  logic boot_on_ok,
   input  logic boot_hold_ok,
   input  logic clamp,
   output logic trip_q,
   output logic trip_d
);
   phase_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (!hs_cmd) begin
         state_d = PH_IDLE;
      end else if (clamp) begin
         state_d = PH_ON;
      end else begin
         unique case (state_q)
            PH_IDLE: state_d = boot_on_ok   ? PH_ON : PH_TRIP;
            PH_ON:   state_d = boot_hold_ok ? PH_ON : PH_TRIP;
            PH_TRIP: state_d = PH_TRIP;
            default: state_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PH_IDLE;
      else        state_q <= state_d;
   end

   assign trip_q = (state_q == PH_TRIP);
   assign trip_d = (state_d == PH_TRIP);

   AST_WEAK_START_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_IDLE && hs_cmd && !clamp && !boot_on_ok) |=> trip_q); // R2
   AST_SAG_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_ON && hs_cmd && !clamp && !boot_hold_ok) |=> trip_q); // R3
   AST_CMD_LOW_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      !hs_cmd |=> !trip_q); // R4
   AST_CLAMP_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      clamp |=> !trip_q); // R6
endmodule

// File: rtl/fault_merge.sv
module fault_merge #(
   parameter int unsigned NUM_PHASES = 2,
   parameter int unsigned NUM_VDS    = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  supply_uv,
   input  logic                  over_temp,
   input  logic [NUM_VDS-1:0]    vds_flt,
   input  logic [NUM_PHASES-1:0] trip_next,
   output logic                  gate_off_all,
   output logic                  flt_drive
);
   logic any_fault;
   assign any_fault = supply_uv | over_temp | (|vds_flt) | (|trip_next);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_off_all <= 1'b1;
         flt_drive    <= 1'b1;
      end else begin
         gate_off_all <= supply_uv;
         flt_drive    <= any_fault;
      end
   end

   AST_UV_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
      supply_uv |=> (gate_off_all && flt_drive)); // R8
   AST_OT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      over_temp |=> flt_drive); // R9
   AST_VDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (|vds_flt) |=> flt_drive); // R10
endmodule

// File: rtl/bootstrap_fault_guard.sv
module bootstrap_fault_guard #(
   parameter int unsigned NUM_PHASES  = 2,
   parameter int unsigned NUM_VDS     = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PHASES-1:0] hs_cmd,
   input  logic [NUM_PHASES-1:0] boot_on_ok,
   input  logic [NUM_PHASES-1:0] boot_hold_ok,
   input  logic                  supply_uv,
   input  logic                  over_temp,
   input  logic [NUM_VDS-1:0]    vds_flt,
   input  logic                  fault_clamp_async,
   output logic [NUM_PHASES-1:0] hs_block,
   output logic                  gate_off_all,
   output logic                  flt_drive
);
   localparam int unsigned MAX_SYNC = 4;

   generate
      if (NUM_PHASES < 1) begin : g_bad_phases
         $error("NUM_PHASES must be at least 1");
      end
      if (NUM_VDS < 1) begin : g_bad_vds
         $error("NUM_VDS must be at least 1");
      end
      if (SYNC_STAGES > MAX_SYNC) begin : g_bad_sync
         $error("SYNC_STAGES exceeds supported depth");
      end
   endgenerate

   logic                  clamp_s;
   logic [NUM_PHASES-1:0] trip_d;

   clamp_sync #(.STAGES(SYNC_STAGES)) i_clamp_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (fault_clamp_async),
      .sync_out (clamp_s)
   );

   generate
      for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
         boot_phase_guard i_guard (
            .clk          (clk),
            .rst_n        (rst_n),
            .hs_cmd       (hs_cmd[p]),
            .boot_on_ok   (boot_on_ok[p]),
            .boot_hold_ok (boot_hold_ok[p]),
            .clamp        (clamp_s),
            .trip_q       (hs_block[p]),
            .trip_d       (trip_d[p])
         );
      end
   endgenerate

   fault_merge #(.NUM_PHASES(NUM_PHASES), .NUM_VDS(NUM_VDS)) i_merge (
      .clk          (clk),
      .rst_n        (rst_n),
      .supply_uv    (supply_uv),
      .over_temp    (over_temp),
      .vds_flt      (vds_flt),
      .trip_next    (trip_d),
      .gate_off_all (gate_off_all),
      .flt_drive    (flt_drive)
   );

   AST_TRIP_RAISES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (|hs_block) |-> flt_drive); // R2
   AST_CMD_LOW_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_cmd == '0) |=> (hs_block == '0)); // R11
endmodule

// File: tb/test_bootstrap_fault_guard.sv
module test_bootstrap_fault_guard;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] hs_cmd = '0, boot_on_ok = '1, boot_hold_ok = '1;
   logic       supply_uv = 1'b1, over_temp = 1'b0, clamp = 1'b0;
   logic [3:0] vds_flt = '0;
   logic [1:0] hs_block;
   logic       gate_off_all, flt_drive;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   typedef struct {
      logic [1:0] blk;
      logic       gate;
      logic       flt;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   always #2 clk = ~clk;

   bootstrap_fault_guard i_bootstrap_fault_guard (
      .clk (clk), .rst_n (rst_n), .hs_cmd (hs_cmd), .boot_on_ok (boot_on_ok),
      .boot_hold_ok (boot_hold_ok), .supply_uv (supply_uv), .over_temp (over_temp),
      .vds_flt (vds_flt), .fault_clamp_async (clamp), .hs_block (hs_block),
      .gate_off_all (gate_off_all), .flt_drive (flt_drive)
   );

   task automatic compare(input exp_t e);
      checks++;
      if (hs_block !== e.blk || gate_off_all !== e.gate || flt_drive !== e.flt) begin
         errors++;
         $display("FAIL %s: blk=%b gate=%b flt=%b expected blk=%b gate=%b flt=%b",
                  e.tag, hs_block, gate_off_all, flt_drive, e.blk, e.gate, e.flt);
      end
   endtask

   // driver: applies inputs at the falling edge, queues the result due at the next rising edge
   task automatic step(input logic [1:0] c, input logic [1:0] on, input logic [1:0] hold,
                       input logic uv, input logic ot, input logic [3:0] v, input logic cl,
                       input logic [1:0] eb, input logic eg, input logic ef, input string tag);
      exp_t e;
      @(negedge clk);
      hs_cmd = c; boot_on_ok = on; boot_hold_ok = hold;
      supply_uv = uv; over_temp = ot; vds_flt = v; clamp = cl;
      e.blk = eb; e.gate = eg; e.flt = ef; e.tag = tag;
      sb_q.push_back(e);
   endtask

   // monitor
   always @(posedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         #1;
         compare(e);
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #20000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      exp_t r;
      repeat (3) @(posedge clk);
      #1;
      r.blk = 2'b00; r.gate = 1'b1; r.flt = 1'b1; r.tag = "R1 reset state";
      compare(r);
      @(negedge clk);
      rst_n = 1'b1;
      //    cmd    on     hold   uv ot vds     cl  blk    gate flt
      step(2'b00, 2'b11, 2'b11, 1, 0, 4'b0000, 0, 2'b00, 1, 1, "R8 uv held");
      step(2'b00, 2'b11, 2'b11, 0, 0, 4'b0000, 0, 2'b00, 0, 0, "R8 uv clears");
      step(2'b01, 2'b11, 2'b11, 0, 0, 4'b0000, 0, 2'b00, 0, 0, "R3 good turn-on");
      step(2'b01, 2'b11, 2'b10, 0, 0, 4'b0000, 0, 2'b01, 0, 1, "R3 sag trips");
      step(2'b01, 2'b11, 2'b11, 0, 0, 4'b0000, 0, 2'b01, 0, 1, "R4 latched");
      step(2'b00, 2'b11, 2'b11, 0, 0, 4'b0000, 0, 2'b00, 0, 0, "R4 release");
      step(2'b11, 2'b01, 2'b11, 0, 0, 4'b0000, 0, 2'b10, 0, 1, "R2 R5 weak start");
      step(2'b01, 2'b01, 2'b11, 0, 0, 4'b0000, 0, 2'b00, 0, 0, "R4 R5 release");
      step(2'b00, 2'b00, 2'b00, 0, 0, 4'b0000, 0, 2'b00, 0, 0, "R11 cmd low");
      step(2'b00, 2'b00, 2'b00, 0, 1, 4'b0000, 0, 2'b00, 0, 1, "R9 overtemp");
      step(2'b00, 2'b11, 2'b11, 0, 0, 4'b0100, 0, 2'b00, 0, 1, "R10 vds");
      step(2'b11, 2'b11, 2'b11, 0, 0, 4'b1000, 0, 2'b00, 0, 1, "R10 no disable");
      step(2'b11, 2'b11, 2'b00, 0, 0, 4'b0000, 0, 2'b11, 0, 1, "R3 both sag");
      step(2'b11, 2'b11, 2'b00, 0, 0, 4'b0000, 1, 2'b11, 0, 1, "R6 clamp edge1");
      step(2'b11, 2'b11, 2'b00, 0, 0, 4'b0000, 1, 2'b11, 0, 1, "R6 clamp edge2");
      step(2'b11, 2'b11, 2'b00, 0, 0, 4'b0000, 1, 2'b00, 0, 0, "R6 clamp clears");
      step(2'b00, 2'b00, 2'b00, 0, 0, 4'b0000, 1, 2'b00, 0, 0, "R6 cmd off");
      step(2'b11, 2'b00, 2'b00, 0, 0, 4'b0000, 1, 2'b00, 0, 0, "R6 no set");
      step(2'b11, 2'b00, 2'b00, 1, 0, 4'b0000, 1, 2'b00, 1, 1, "R7 uv under clamp");
      step(2'b11, 2'b11, 2'b11, 0, 0, 4'b0000, 0, 2'b00, 0, 0, "R7 uv clears");
      step(2'b11, 2'b11, 2'b11, 0, 0, 4'b0000, 0, 2'b00, 0, 0, "R6 release sync");
      step(2'b11, 2'b11, 2'b11, 0, 0, 4'b0000, 0, 2'b00, 0, 0, "R6 release done");
      step(2'b11, 2'b11, 2'b01, 0, 0, 4'b0000, 0, 2'b10, 0, 1, "R6 re-armed");
      step(2'b00, 2'b11, 2'b11, 0, 0, 4'b0000, 0, 2'b00, 0, 0, "R4 clear");
      step(2'b11, 2'b00, 2'b11, 1, 0, 4'b0000, 0, 2'b11, 1, 1, "R2 R8 same edge");
      step(2'b11, 2'b00, 2'b11, 0, 0, 4'b0000, 0, 2'b11, 0, 1, "R8 no latch R4");
      step(2'b00, 2'b11, 2'b11, 0, 0, 4'b0000, 0, 2'b00, 0, 0, "R4 final clear");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule